// File: doc/BRIEF.md
# Reset and Power-State Sequencer

This block merges three asynchronous active-low reset sources into layered internal resets and runs the power-state machine that brings a processor subsystem out of Standby. The power-on input is the deepest reset. It clears everything, including a small retention register and the status flags. The power-fail and user resets only reach the system reset domain, which holds the state machine and the clock-enable logic. Every reset asserts at once without waiting for a clock. Each one is released through a synchroniser on the reference clock.

After power-on the block sits in Standby with the PLL and the CPU clock off. It listens to a wake input only after a blanking window has passed. The wake input is synchronised and must stay high for a programmable number of consecutive cycles before it is accepted. Acceptance turns on the PLL enable. After a fixed settle count the CPU clock enable comes on and the block is Operating. Acceptance is one-shot: only a new power-on reset arms the wake input again.

While Operating, a level request moves the block into Idle, where the CPU clock stops but the PLL keeps running. A user reset that arrives after a wake is accepted but before Operating is reached is recorded as an illegal event in the status word. All durations are parameters counted in reference-clock cycles.

Top module: `rst_pwr_seq`

## Requirements
- R1: `sys_rst_no` goes low in the same instant that any of `rst_ni`, `pwrfail_ni` or `user_rst_ni` is low. It returns high two reference-clock edges after all three are high.
- R2: While the system reset is active and right after it releases, the block is in Standby. In Standby `pwr_state_o` is 0 and `run_o`, `pll_en_o` and `cpu_clk_en_o` are all 0. The state codes are 0 Standby, 1 Settle, 2 Operating, 3 Idle.
- R3: Wake activity during the first BLANK_CYC cycles after power-on release is ignored, even a pulse longer than DG_CYC.
- R4: A wake pulse shorter than DG_CYC consecutive cycles is rejected, and a low cycle restarts the count. A pulse of exactly DG_CYC cycles is accepted: `pll_en_o` rises and the state becomes 1.
- R5: `cpu_clk_en_o` and `run_o` rise exactly SETTLE_CYC cycles after entry into state 1. Settle never lasts longer than the bound SETTLE_MAX.
- R6: After one accepted wake, the wake input has no effect until the next power-on reset. This holds in Idle and in Standby after a power-fail or user reset.
- R7: In Operating, `idle_req_i` high moves the block to Idle one cycle later, with `cpu_clk_en_o`=0, `pll_en_o`=1 and `run_o`=1. `idle_req_i` low moves it back to Operating.
- R8: An active system reset forces Standby with `run_o` low from any state, without waiting for a clock.
- R9: `sys_flag_o` bit 15 is the cold flag: power-on sets it and clears every other flag. Bit 0 records a power-fail reset. `stat_clr_i` clears all flags. Power-fail and user resets never clear any flag and never set bit 15.
- R10: A user reset while in state 1 sets `sys_flag_o` bit 1. A wake that reaches Operating without one leaves bit 1 clear.
- R11: `keep_q_o` loads `keep_d_i` on `keep_we_i`. Only power-on clears it, and it holds through power-fail and user resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, async, active low |
| pwrfail_ni | input | 1 | Power-fail reset, async, active low |
| user_rst_ni | input | 1 | User reset, async, active low |
| wake_i | input | 1 | Wake request, asynchronous, active high |
| idle_req_i | input | 1 | Idle request level, synchronous |
| stat_clr_i | input | 1 | Clear all status flags |
| keep_we_i | input | 1 | Retention register write enable |
| keep_d_i | input | KEEP_W | Retention register write data |
| sys_rst_no | output | 1 | Internal system reset, active low |
| run_o | output | 1 | High in Operating and Idle |
| pll_en_o | output | 1 | PLL enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| pwr_state_o | output | 2 | Power-state code |
| sys_flag_o | output | 16 | Status flags (15 cold, 1 illegal reset, 0 power-fail) |
| keep_q_o | output | KEEP_W | Retention register contents |

## Verification
The bench drives wake pulses one cycle short of the deglitch threshold, a short pulse split by a single low cycle, and a pulse exactly at the threshold. An off-by-one filter would accept the short pulse or reject the exact one. It also drives a long pulse inside the blanking window and wake pulses in Idle and after a non-power-on reset. A filter that blanks too briefly, or re-arms on the system reset, would start the PLL there. The bench counts the settle period to the exact cycle. It asserts a user reset during Settle to confirm the illegal flag latches. Power-fail, user and power-on resets are interleaved so that a status flag or the retention register cleared by the wrong reset layer shows up at the ports.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;
  typedef enum logic [1:0] {
    PS_STANDBY = 2'd0,
    PS_SETTLE  = 2'd1,
    PS_OPER    = 2'd2,
    PS_IDLE    = 2'd3
  } pwr_state_e;

  localparam int unsigned FLAG_W   = 16;
  localparam int unsigned COLD_BIT = 15;
  localparam int unsigned ILL_BIT  = 1;
  localparam int unsigned PF_BIT   = 0;
endpackage

// File: rtl/rps_rst_sync.sv
`timescale 1ns/1ps
// Async assert, synchronous release.
module rps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/rps_sync.sv
`timescale 1ns/1ps
module rps_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rps_wake_filter.sv
`timescale 1ns/1ps
// Blanking after power-on, consecutive-high deglitch, one-shot acceptance.
module rps_wake_filter #(
  parameter int unsigned BLANK_CYC   = 64,
  parameter int unsigned DG_CYC      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic listen_i,
  output logic acc_o,
  output logic used_o
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam int unsigned DW = $clog2(DG_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
  localparam logic [DW-1:0] DG_LAST   = DW'(DG_CYC - 1);

  logic          wake_s;
  logic [BW-1:0] blank_cnt;
  logic [DW-1:0] dg_cnt;
  logic          blank_done;
  logic          arm;
  logic          used_q;

  rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_i),
    .q_o   (wake_s)
  );

  assign blank_done = (blank_cnt == BLANK_END);
  assign arm        = blank_done & ~used_q & listen_i;
  assign acc_o      = arm & wake_s & (dg_cnt == DG_LAST);
  assign used_o     = used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_cnt <= '0;
    end else if (!blank_done) begin
      blank_cnt <= blank_cnt + BW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dg_cnt <= '0;
    end else if (!arm || !wake_s) begin
      dg_cnt <= '0;
    end else if (dg_cnt != DG_LAST) begin
      dg_cnt <= dg_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    used_q <= 1'b0;
    else if (acc_o) used_q <= 1'b1;
  end
endmodule

// File: rtl/rps_pwr_fsm.sv
`timescale 1ns/1ps
module rps_pwr_fsm import rps_pkg::*; #(
  parameter int unsigned SETTLE_CYC = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       idle_req_i,
  output pwr_state_e state_o,
  output logic       pll_en_o,
  output logic       cpu_en_o,
  output logic       run_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  pwr_state_e st_q, st_d;
  logic [SW-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_STANDBY: if (acc_i)                st_d = PS_SETTLE;
      PS_SETTLE:  if (cnt_q == SETTLE_LAST) st_d = PS_OPER;
      PS_OPER:    if (idle_req_i)           st_d = PS_IDLE;
      PS_IDLE:    if (!idle_req_i)          st_d = PS_OPER;
      default:                              st_d = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_STANDBY;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == PS_SETTLE) ? cnt_q + SW'(1) : '0;
    end
  end

  assign state_o  = st_q;
  assign pll_en_o = (st_q != PS_STANDBY);
  assign cpu_en_o = (st_q == PS_OPER);
  assign run_o    = (st_q == PS_OPER) || (st_q == PS_IDLE);
endmodule

// File: rtl/rst_pwr_seq.sv
`timescale 1ns/1ps
module rst_pwr_seq import rps_pkg::*; #(
  parameter int unsigned BLANK_CYC   = 64,
  parameter int unsigned DG_CYC      = 16,
  parameter int unsigned SETTLE_CYC  = 40,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned KEEP_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrfail_ni,
  input  logic              user_rst_ni,
  input  logic              wake_i,
  input  logic              idle_req_i,
  input  logic              stat_clr_i,
  input  logic              keep_we_i,
  input  logic [KEEP_W-1:0] keep_d_i,
  output logic              sys_rst_no,
  output logic              run_o,
  output logic              pll_en_o,
  output logic              cpu_clk_en_o,
  output logic [1:0]        pwr_state_o,
  output logic [FLAG_W-1:0] sys_flag_o,
  output logic [KEEP_W-1:0] keep_q_o
);
  logic       por_n;
  logic       sys_raw_n;
  logic       sys_n;
  logic       usr_s;
  logic       pf_s;
  logic       acc;
  logic       used;
  logic       listen;
  logic       win_q;
  logic       err_set;
  logic       cold_q, ill_q, pf_q;
  pwr_state_e state;
  logic [KEEP_W-1:0] keep_q;

  // Reset layering: power-on domain and system domain.
  assign sys_raw_n = rst_ni & pwrfail_ni & user_rst_ni;

  rps_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (por_n)
  );

  rps_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i  (clk_i),
    .arst_ni(sys_raw_n),
    .rst_no (sys_n)
  );

  rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_usr_sync (
    .clk_i (clk_i),
    .rst_ni(por_n),
    .d_i   (user_rst_ni),
    .q_o   (usr_s)
  );

  rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pf_sync (
    .clk_i (clk_i),
    .rst_ni(por_n),
    .d_i   (pwrfail_ni),
    .q_o   (pf_s)
  );

  assign listen = sys_n & (state == PS_STANDBY);

  rps_wake_filter #(
    .BLANK_CYC  (BLANK_CYC),
    .DG_CYC     (DG_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (por_n),
    .wake_i  (wake_i),
    .listen_i(listen),
    .acc_o   (acc),
    .used_o  (used)
  );

  rps_pwr_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (sys_n),
    .acc_i     (acc),
    .idle_req_i(idle_req_i),
    .state_o   (state),
    .pll_en_o  (pll_en_o),
    .cpu_en_o  (cpu_clk_en_o),
    .run_o     (run_o)
  );

  // Wake window: accepted but Operating not yet reached.
  assign err_set = win_q & ~usr_s;

  always_ff @(posedge clk_i or negedge por_n) begin
    if (!por_n)                              win_q <= 1'b0;
    else if (acc)                            win_q <= 1'b1;
    else if (state == PS_OPER || err_set)    win_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge por_n) begin
    if (!por_n) begin
      cold_q <= 1'b1;
      ill_q  <= 1'b0;
      pf_q   <= 1'b0;
    end else begin
      if (stat_clr_i) begin
        cold_q <= 1'b0;
        ill_q  <= 1'b0;
        pf_q   <= 1'b0;
      end
      if (!pf_s)   pf_q  <= 1'b1;
      if (err_set) ill_q <= 1'b1;
    end
  end

  always_comb begin
    sys_flag_o           = '0;
    sys_flag_o[COLD_BIT] = cold_q;
    sys_flag_o[ILL_BIT]  = ill_q;
    sys_flag_o[PF_BIT]   = pf_q;
  end

  // Retention storage, power-on domain only.
  always_ff @(posedge clk_i or negedge por_n) begin
    if (!por_n)         keep_q <= '0;
    else if (keep_we_i) keep_q <= keep_d_i;
  end

  assign keep_q_o    = keep_q;
  assign sys_rst_no  = sys_n;
  assign pwr_state_o = state;
endmodule

// File: rtl/rst_pwr_seq_chk.sv
`timescale 1ns/1ps
module rst_pwr_seq_chk import rps_pkg::*; #(
  parameter int unsigned SETTLE_MAX = 64,
  parameter int unsigned KEEP_W     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwrfail_ni,
  input logic              user_rst_ni,
  input logic              idle_req_i,
  input logic              stat_clr_i,
  input logic              keep_we_i,
  input logic              sys_rst_no,
  input logic              run_o,
  input logic              pll_en_o,
  input logic              cpu_clk_en_o,
  input logic [1:0]        pwr_state_o,
  input logic [FLAG_W-1:0] sys_flag_o,
  input logic [KEEP_W-1:0] keep_q_o
);
  logic [15:0] settle_cnt;
  logic        woke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          settle_cnt <= '0;
    else if (pwr_state_o != 2'd1)         settle_cnt <= '0;
    else if (settle_cnt != 16'hffff)      settle_cnt <= settle_cnt + 16'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       woke_q <= 1'b0;
    else if (pll_en_o) woke_q <= 1'b1;
  end

  assert_sys_rst_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwrfail_ni || !user_rst_ni) |-> !sys_rst_no);

  assert_sys_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(pwrfail_ni && user_rst_ni, 2));

  assert_reset_forces_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> (!run_o && !pll_en_o && !cpu_clk_en_o));

  assert_cpu_needs_pll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (pll_en_o && run_o));

  assert_settle_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd1) |-> (settle_cnt < 16'(SETTLE_MAX)));

  assert_wake_oneshot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> !woke_q);

  assert_idle_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2 && idle_req_i && sys_rst_no) |=> (pwr_state_o == 2'd3 || !sys_rst_no));

  assert_cold_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_flag_o[COLD_BIT]) |-> $past(stat_clr_i));

  assert_keep_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(keep_we_i) |-> $stable(keep_q_o));
endmodule

bind rst_pwr_seq rst_pwr_seq_chk #(.KEEP_W(KEEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwrfail_ni  (pwrfail_ni),
  .user_rst_ni (user_rst_ni),
  .idle_req_i  (idle_req_i),
  .stat_clr_i  (stat_clr_i),
  .keep_we_i   (keep_we_i),
  .sys_rst_no  (sys_rst_no),
  .run_o       (run_o),
  .pll_en_o    (pll_en_o),
  .cpu_clk_en_o(cpu_clk_en_o),
  .pwr_state_o (pwr_state_o),
  .sys_flag_o  (sys_flag_o),
  .keep_q_o    (keep_q_o)
);

// File: tb/rst_pwr_seq_bench.sv
`timescale 1ns/1ps
module rst_pwr_seq_bench;
  localparam int unsigned BLANK  = 64;
  localparam int unsigned DG     = 16;
  localparam int unsigned SETTLE = 40;
  localparam int unsigned KW     = 32;

  localparam int SEL_SYS = 0, SEL_RUN = 1, SEL_PLL = 2, SEL_CPU = 3,
                 SEL_ST = 4, SEL_FLG = 5, SEL_KEEP = 6, SEL_BIT = 7;

  logic clk = 1'b0;
  logic rst_ni, pwrfail_ni, user_rst_ni, wake_i, idle_req_i, stat_clr_i, keep_we_i;
  logic [KW-1:0] keep_d_i;
  logic sys_rst_no, run_o, pll_en_o, cpu_clk_en_o;
  logic [1:0] pwr_state_o;
  logic [15:0] sys_flag_o;
  logic [KW-1:0] keep_q_o;

  always #2.5 clk = ~clk;

  rst_pwr_seq #(
    .BLANK_CYC(BLANK), .DG_CYC(DG), .SETTLE_CYC(SETTLE), .KEEP_W(KW)
  ) u_rst_pwr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pwrfail_ni(pwrfail_ni), .user_rst_ni(user_rst_ni),
    .wake_i(wake_i), .idle_req_i(idle_req_i), .stat_clr_i(stat_clr_i),
    .keep_we_i(keep_we_i), .keep_d_i(keep_d_i), .sys_rst_no(sys_rst_no),
    .run_o(run_o), .pll_en_o(pll_en_o), .cpu_clk_en_o(cpu_clk_en_o),
    .pwr_state_o(pwr_state_o), .sys_flag_o(sys_flag_o), .keep_q_o(keep_q_o)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       n_vec  = 0;
  int       n_bad  = 0;
  logic     done   = 1'b0;
  logic     found;
  localparam logic [31:0] KEEP_VAL = 32'hA5C3_0F12;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      SEL_SYS:  return {31'd0, sys_rst_no};
      SEL_RUN:  return {31'd0, run_o};
      SEL_PLL:  return {31'd0, pll_en_o};
      SEL_CPU:  return {31'd0, cpu_clk_en_o};
      SEL_ST:   return {30'd0, pwr_state_o};
      SEL_FLG:  return {16'd0, sys_flag_o};
      SEL_KEEP: return keep_q_o;
      default:  return {31'd0, found};
    endcase
  endfunction

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = observe(it.sel);
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expect_o(string req, int sel, logic [31:0] exp);
    sb_item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    -> sb_ev;
    #0.1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    wake_i = 1'b1;
    tick(n);
    wake_i = 1'b0;
  endtask

  task automatic wait_pll();
    found = 1'b0;
    for (int i = 0; i < 20 && !found; i++) begin
      tick(1);
      if (pll_en_o) found = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pwrfail_ni = 1'b1; user_rst_ni = 1'b1; wake_i = 1'b0;
    idle_req_i = 1'b0; stat_clr_i = 1'b0; keep_we_i = 1'b0; keep_d_i = '0;
    tick(3);
    expect_o("R1 reset active", SEL_SYS, 0);
    expect_o("R2 run off", SEL_RUN, 0);
    expect_o("R2 pll off", SEL_PLL, 0);
    expect_o("R2 cpu off", SEL_CPU, 0);
    expect_o("R9 cold flag after power-on", SEL_FLG, 32'h8000);
    expect_o("R11 keep cleared", SEL_KEEP, 0);

    rst_ni = 1'b1;
    tick(3);
    expect_o("R1 release", SEL_SYS, 1);
    expect_o("R2 standby", SEL_ST, 0);

    // R3: long pulse inside blanking
    pulse(40);
    tick(60);
    expect_o("R3 blank ignores wake", SEL_PLL, 0);
    expect_o("R3 still standby", SEL_ST, 0);

    // R4: short and split pulses
    pulse(DG - 1);
    tick(10);
    expect_o("R4 short pulse rejected", SEL_PLL, 0);
    pulse(DG - 1);
    tick(1);
    pulse(DG - 1);
    tick(10);
    expect_o("R4 split pulse rejected", SEL_PLL, 0);

    pulse(DG);
    wait_pll();
    expect_o("R4 exact pulse accepted", SEL_BIT, 1);
    expect_o("R4 settle state", SEL_ST, 1);
    expect_o("R10 no illegal flag", SEL_FLG, 32'h8000);
    tick(SETTLE - 1);
    expect_o("R5 cpu still off", SEL_CPU, 0);
    tick(1);
    expect_o("R5 cpu on", SEL_CPU, 1);
    expect_o("R5 run on", SEL_RUN, 1);
    expect_o("R5 operating", SEL_ST, 2);

    // R7 idle, R6 wake ignored in idle
    idle_req_i = 1'b1;
    tick(1);
    expect_o("R7 idle state", SEL_ST, 3);
    expect_o("R7 idle cpu off", SEL_CPU, 0);
    expect_o("R7 idle pll on", SEL_PLL, 1);
    expect_o("R7 idle run on", SEL_RUN, 1);
    pulse(30);
    tick(5);
    expect_o("R6 wake ignored in idle", SEL_ST, 3);
    idle_req_i = 1'b0;
    tick(1);
    expect_o("R7 back to operating", SEL_ST, 2);
    expect_o("R7 cpu back on", SEL_CPU, 1);

    keep_d_i = KEEP_VAL; keep_we_i = 1'b1;
    tick(1);
    keep_we_i = 1'b0; keep_d_i = '0;
    expect_o("R11 keep written", SEL_KEEP, KEEP_VAL);

    // R8: power-fail from operating
    pwrfail_ni = 1'b0;
    #0.5;
    expect_o("R1 async assert", SEL_SYS, 0);
    expect_o("R8 run dropped", SEL_RUN, 0);
    expect_o("R8 standby forced", SEL_ST, 0);
    tick(3);
    pwrfail_ni = 1'b1;
    tick(4);
    expect_o("R8 standby after power-fail", SEL_ST, 0);
    expect_o("R9 power-fail flag", SEL_FLG, 32'h8001);
    expect_o("R11 keep survives power-fail", SEL_KEEP, KEEP_VAL);
    pulse(30);
    tick(10);
    expect_o("R6 no rearm after power-fail", SEL_PLL, 0);

    stat_clr_i = 1'b1;
    tick(1);
    stat_clr_i = 1'b0;
    expect_o("R9 flags cleared", SEL_FLG, 0);
    user_rst_ni = 1'b0;
    tick(3);
    expect_o("R8 user reset run low", SEL_RUN, 0);
    user_rst_ni = 1'b1;
    tick(4);
    expect_o("R9 user reset sets no flag", SEL_FLG, 0);
    expect_o("R11 keep survives user reset", SEL_KEEP, KEEP_VAL);

    rst_ni = 1'b0;
    #0.5;
    expect_o("R11 keep cleared by power-on", SEL_KEEP, 0);
    expect_o("R9 cold set by power-on", SEL_FLG, 32'h8000);
    tick(3);
    rst_ni = 1'b1;
    tick(BLANK + 6);

    // R10: user reset inside settle window
    pulse(DG);
    wait_pll();
    expect_o("R6 rearmed by power-on", SEL_BIT, 1);
    tick(5);
    user_rst_ni = 1'b0;
    tick(3);
    user_rst_ni = 1'b1;
    tick(4);
    expect_o("R10 illegal flag", SEL_FLG, 32'h8002);
    expect_o("R10 standby after illegal reset", SEL_ST, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule